// File: doc/BRIEF.md
# Peripheral Clock Control Unit

This block derives a peripheral clock enable from the main system clock. A 2-bit selection chosen by software sets the division ratio. The enable is a one-cycle strobe in the system clock domain: peripheral logic advances only on cycles where the strobe is high. A change of ratio waits for the end of the current divided period, so the strobe never shows a short period.

The block also controls the enable of a free-running low-speed oscillator, which is modelled here as an input tick. A watchdog and a general timer consume that tick. They keep counting in standby, when the strobe derived from the system clock is held off. A configuration bit is captured while reset is asserted. When it is set, the low-speed oscillator is locked on and the watchdog is forced onto the low-speed source. Software stop writes and source-select writes then have no effect.

Top module: `pclk_ctrl`

## Requirements
- R1: With the active selection at code 0, `pclk_en_o` is high on every cycle. Code 1 makes it high on one cycle in 2, and code 2 on one cycle in 4. Each strobe lasts one cycle.
- R2: A write of code 3 is ignored. The selection in effect and the pending selection both stay as they were.
- R3: An accepted selection write takes effect only at a period boundary. The divided period already under way completes at the old ratio, and every later period uses the new ratio.
- R4: While `rst_n` is low, `pclk_en_o` is low and `lso_en_o` is high. Reset sets the selection to code 0, sets the stop bit to running, and sets the watchdog source to 0, the peripheral clock. After release, `lso_en_o` stays high until software stops the oscillator.
- R5: `cfg_lock_i` is sampled on clock edges while `rst_n` is low. The captured value holds until the next reset, whatever the input does after release.
- R6: When unlocked, a stop write of 1 drives `lso_en_o` low from the next cycle, and a write of 0 drives it high again.
- R7: When locked, stop writes have no effect, and `lso_en_o` and `wdt_src_o` both stay at 1.
- R8: When unlocked, `wdt_src_o` takes the written value (1 = low-speed oscillator, 0 = peripheral clock) on the cycle after a source write.
- R9: While `standby_i` is high, `pclk_en_o` is low in that same cycle. `lso_en_o` keeps the value it had before standby.
- R10: `lso_tick_o` equals `lso_tick_i` while `lso_en_o` is high and is 0 otherwise. This holds in standby as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lock_i | input | 1 | Lock configuration, captured during reset |
| div_wr_i | input | 1 | Divider selection write strobe |
| div_sel_i | input | 2 | Divider selection code |
| lso_stop_wr_i | input | 1 | Stop bit write strobe |
| lso_stop_i | input | 1 | Stop bit value (1 = stop) |
| wdt_src_wr_i | input | 1 | Watchdog source write strobe |
| wdt_src_i | input | 1 | Watchdog source value (1 = low-speed) |
| standby_i | input | 1 | Standby indication |
| lso_tick_i | input | 1 | Tick from the low-speed oscillator |
| pclk_en_o | output | 1 | Peripheral clock enable strobe |
| lso_en_o | output | 1 | Low-speed oscillator enable |
| wdt_src_o | output | 1 | Watchdog clock source in effect |
| lso_tick_o | output | 1 | Gated low-speed tick for the watchdog and timer |

## Verification
A write to the stop bit or the source register shows at the outputs one cycle after the edge that samples it. A divider write shows only at the next period boundary, which may be up to four cycles later. Standby and the low-speed tick act combinationally, in the same cycle. The bench model applies every input at the clock edge the design sees and works out the outputs that follow. It compares them 2 ns after each rising edge, after the registers have settled and before the next input change at the falling edge. Strobe counts over whole-period windows cover the ratio checks without depending on phase.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int SEL_W = 2;
  // largest valid code gives the longest period; counter spans it
  localparam int MAX_CODE = (1 << SEL_W) - 2;
  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;
  localparam logic [SEL_W-1:0] SEL_BAD = '1;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {WSRC_PCLK = 1'b0, WSRC_LSO = 1'b1} wdt_src_e;

  function automatic logic sel_ok(sel_t s);
    return s != SEL_BAD;
  endfunction

  // index of last cycle in a period of length 2**s
  function automatic cnt_t last_phase(sel_t s);
    logic [CNT_W:0] len;
    len = (CNT_W + 1)'(1) << s;
    return CNT_W'(len - 1'b1);
  endfunction
endpackage

// File: rtl/pclk_div.sv
module pclk_div
  import pclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  sel_t sel_i,
  input  logic standby_i,
  output logic strobe_o,
  output sel_t act_sel_o,
  output sel_t pend_sel_o,
  output logic period_end_o
);
  cnt_t phase_q;
  sel_t act_q, pend_q;
  logic accept;

  assign accept       = wr_i & sel_ok(sel_i);
  assign period_end_o = (phase_q == last_phase(act_q));
  assign strobe_o     = rst_n & (phase_q == '0) & ~standby_i;
  assign act_sel_o    = act_q;
  assign pend_sel_o   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      act_q   <= '0;
      pend_q  <= '0;
    end else begin
      if (period_end_o) begin
        phase_q <= '0;
        act_q   <= pend_q;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
      if (accept) pend_q <= sel_i;
    end
  end
endmodule

// File: rtl/pclk_lso.sv
module pclk_lso
  import pclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_lock_i,
  input  logic stop_wr_i,
  input  logic stop_i,
  input  logic src_wr_i,
  input  logic src_i,
  input  logic tick_i,
  output logic lock_o,
  output logic stop_accept_o,
  output logic lso_en_o,
  output logic wdt_src_o,
  output logic tick_o
);
  logic lock_q, stop_q;
  wdt_src_e src_q;

  assign stop_accept_o = stop_wr_i & ~lock_q;
  assign lock_o        = lock_q;
  assign lso_en_o      = lock_q | ~stop_q;
  assign wdt_src_o     = lock_q | (src_q == WSRC_LSO);
  assign tick_o        = tick_i & lso_en_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= cfg_lock_i;
      stop_q <= 1'b0;
      src_q  <= WSRC_PCLK;
    end else begin
      if (stop_accept_o) stop_q <= stop_i;
      if (src_wr_i) src_q <= wdt_src_e'(src_i);
    end
  end
endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_lock_i,
  input  logic       div_wr_i,
  input  logic [1:0] div_sel_i,
  input  logic       lso_stop_wr_i,
  input  logic       lso_stop_i,
  input  logic       wdt_src_wr_i,
  input  logic       wdt_src_i,
  input  logic       standby_i,
  input  logic       lso_tick_i,
  output logic       pclk_en_o,
  output logic       lso_en_o,
  output logic       wdt_src_o,
  output logic       lso_tick_o
);
  sel_t act_sel, pend_sel;
  logic period_end, lock, stop_accept;

  pclk_div u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (div_wr_i),
    .sel_i       (div_sel_i),
    .standby_i   (standby_i),
    .strobe_o    (pclk_en_o),
    .act_sel_o   (act_sel),
    .pend_sel_o  (pend_sel),
    .period_end_o(period_end)
  );

  pclk_lso u_lso (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_lock_i   (cfg_lock_i),
    .stop_wr_i    (lso_stop_wr_i),
    .stop_i       (lso_stop_i),
    .src_wr_i     (wdt_src_wr_i),
    .src_i        (wdt_src_i),
    .tick_i       (lso_tick_i),
    .lock_o       (lock),
    .stop_accept_o(stop_accept),
    .lso_en_o     (lso_en_o),
    .wdt_src_o    (wdt_src_o),
    .tick_o       (lso_tick_o)
  );
endmodule

// File: rtl/pclk_ctrl_chk.sv
module pclk_ctrl_chk
  import pclk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic div_wr_i,
  input sel_t div_sel_i,
  input logic lso_stop_i,
  input logic standby_i,
  input logic pclk_en_o,
  input logic lso_en_o,
  input logic wdt_src_o,
  input sel_t act_sel,
  input sel_t pend_sel,
  input logic period_end,
  input logic lock,
  input logic stop_accept
);
  assert_period_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (pclk_en_o || standby_i));

  assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr_i && div_sel_i == SEL_BAD) |=> $stable(pend_sel));

  assert_switch_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sel) |-> $past(period_end));

  assert_running_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lso_en_o && act_sel == '0));

  assert_stop_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_accept |=> (lso_en_o == !$past(lso_stop_i)));

  assert_locked_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (lso_en_o && wdt_src_o));

  assert_standby_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |-> !pclk_en_o);
endmodule

bind pclk_ctrl pclk_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_wr_i   (div_wr_i),
  .div_sel_i  (div_sel_i),
  .lso_stop_i (lso_stop_i),
  .standby_i  (standby_i),
  .pclk_en_o  (pclk_en_o),
  .lso_en_o   (lso_en_o),
  .wdt_src_o  (wdt_src_o),
  .act_sel    (act_sel),
  .pend_sel   (pend_sel),
  .period_end (period_end),
  .lock       (lock),
  .stop_accept(stop_accept)
);

// File: tb/sim_pclk_ctrl.sv
`timescale 1ns/1ps
module sim_pclk_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cfg = 1'b0;
  logic div_wr = 1'b0, stop_wr = 1'b0, stop_v = 1'b0, src_wr = 1'b0, src_v = 1'b0;
  logic standby = 1'b0, tick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic pclk_en, lso_en, wdt_src, tick_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_len = 1, m_want = 1, m_pos = 0;
  bit m_lock = 0, m_stop = 0, m_src = 0;

  always #5 clk = ~clk;

  pclk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lock_i(cfg), .div_wr_i(div_wr), .div_sel_i(sel),
    .lso_stop_wr_i(stop_wr), .lso_stop_i(stop_v), .wdt_src_wr_i(src_wr),
    .wdt_src_i(src_v), .standby_i(standby), .lso_tick_i(tick),
    .pclk_en_o(pclk_en), .lso_en_o(lso_en), .wdt_src_o(wdt_src), .lso_tick_o(tick_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // reference update at the edge, comparison 2 ns later
  always @(posedge clk) begin
    bit e_lso;
    cyc++;
    if (!rst_n) begin
      m_lock = cfg; m_stop = 0; m_src = 0; m_len = 1; m_want = 1; m_pos = 0;
    end else begin
      if (m_pos + 1 >= m_len) begin m_pos = 0; m_len = m_want; end
      else m_pos++;
      if (div_wr && sel != 2'd3) m_want = 1 << sel;
      if (stop_wr && !m_lock) m_stop = stop_v;
      if (src_wr) m_src = src_v;
    end
    #2;
    if (cyc > 1 && !done) begin
      e_lso = m_lock || !m_stop;
      check("R1/R2/R3/R4/R9 pclk_en", pclk_en, rst_n && m_pos == 0 && !standby);
      check("R4/R5/R6/R7/R9 lso_en", lso_en, e_lso);
      check("R5/R7/R8 wdt_src", wdt_src, m_lock || m_src);
      check("R10 lso_tick", tick_o, tick && e_lso);
    end
  end

  // low-speed tick pattern, independent of the system clock phase
  always @(negedge clk) tick <= ($urandom % 3) == 0;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_div(input logic [1:0] s);
    @(negedge clk); div_wr = 1; sel = s;
    @(negedge clk); div_wr = 0;
  endtask

  task automatic put_stop(input logic v);
    @(negedge clk); stop_wr = 1; stop_v = v;
    @(negedge clk); stop_wr = 0;
  endtask

  task automatic put_src(input logic v);
    @(negedge clk); src_wr = 1; src_v = v;
    @(negedge clk); src_wr = 0;
  endtask

  task automatic count_strobes(input int n, input int exp, input string tag);
    int c = 0;
    repeat (n) begin @(posedge clk); #3; if (pclk_en) c++; end
    checks++;
    if (c != exp) begin
      fails++;
      $display("FAIL %s strobe count: actual %0d expected %0d", tag, c, exp);
    end
  endtask

  task automatic do_reset(input logic lock_cfg);
    @(negedge clk); rst_n = 0; cfg = lock_cfg;
    wait_cyc(3);
    @(posedge clk); #3;
    check("R4 pclk_en low in reset", pclk_en, 1'b0);
    check("R4 lso_en high in reset", lso_en, 1'b1);
    @(negedge clk); rst_n = 1; cfg = ~lock_cfg;  // later changes must not matter (R5)
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // unlocked session
    do_reset(1'b0);
    wait_cyc(2);
    count_strobes(8, 8, "R1 code 0");
    put_div(2'd1); wait_cyc(4);
    count_strobes(8, 4, "R1 code 1");
    put_div(2'd2); wait_cyc(6);
    count_strobes(16, 4, "R1 code 2");
    put_div(2'd3); wait_cyc(6);
    count_strobes(16, 4, "R2 code 3 ignored");
    put_div(2'd0); put_div(2'd1); wait_cyc(3);   // R3 back-to-back switches
    @(negedge clk); standby = 1;
    count_strobes(8, 0, "R9 standby gate");
    @(negedge clk); standby = 0;
    put_stop(1'b1); wait_cyc(4);
    @(negedge clk); standby = 1; wait_cyc(5);     // R9 lso_en keeps stopped state
    @(negedge clk); standby = 0;
    put_stop(1'b0); wait_cyc(3);
    @(negedge clk); standby = 1; wait_cyc(6);     // R10 ticks pass in standby
    @(negedge clk); standby = 0;
    put_src(1'b1); wait_cyc(2);
    put_src(1'b0); wait_cyc(2);
    put_div(2'd2); put_div(2'd3); wait_cyc(10);
    // locked session
    do_reset(1'b1);
    wait_cyc(2);
    put_stop(1'b1); wait_cyc(3);
    put_src(1'b0); wait_cyc(3);
    @(posedge clk); #3;
    check("R7 lso_en locked", lso_en, 1'b1);
    check("R7 wdt_src forced", wdt_src, 1'b1);
    @(negedge clk); standby = 1; wait_cyc(4);
    @(negedge clk); standby = 0;
    put_div(2'd1); wait_cyc(8);
    // unlocked again: source register returns to reset value
    do_reset(1'b0);
    wait_cyc(2);
    @(posedge clk); #3;
    check("R4 wdt_src reset", wdt_src, 1'b0);
    check("R5 lock released", lso_en, 1'b1);
    put_stop(1'b1); wait_cyc(2);
    @(posedge clk); #3;
    check("R6 stop honoured", lso_en, 1'b0);
    wait_cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule